// File: doc/BRIEF.md
# Register-Mapped Factorial Accelerator

This block is a small memory-mapped slave built around an iterative factorial engine. Next to the engine it holds a fixed identification word and a scratch register that keeps the bitwise inverse of whatever software last wrote to it. The slave port is a 32-bit request interface that carries a byte address and an access size in bytes. Each read is answered one cycle later on a registered response bus.

Software writes an operand to the operand register and then polls the busy bit in the status register. Once the busy bit drops, software reads the result back from the same operand register, where it has replaced the operand. The engine does one multiply per clock while it counts the operand down to zero. A status-register enable bit selects whether completion also sends a one-cycle event to an external interrupt unit.

The map uses four words. Offset 0x00 holds the identification word. Offset 0x04 holds the inverted scratch value. Offset 0x08 holds the operand and, after completion, the result. Offset 0x20 holds the status, with the busy bit at bit 0 and the completion event enable at bit 7. Every other offset is unmapped.

Top module: `fa_accel`

## Requirements
- R1: A 4-byte read of offset 0x00 returns 0x010000ED, and a write to that offset changes nothing.
- R2: A 4-byte write to offset 0x04 stores the bitwise complement of the write data, and a 4-byte read of 0x04 returns the stored value.
- R3: While the engine is idle, a 4-byte write to offset 0x08 loads the operand and sets status bit 0. Until the result lands, reads of 0x08 return that operand.
- R4: A write to offset 0x08 while status bit 0 is set is refused, and the running computation and its result are unaffected.
- R5: On completion, offset 0x08 holds n·(n−1)·…·1 modulo 2^32, and status bit 0 clears. An operand of 0 yields 1.
- R6: One multiply is done per clock. A status read issued k cycles after the cycle of the operand write shows bit 0 set exactly while k ≤ n+1, so n status polls that start two cycles after the write see it busy.
- R7: Status bit 7 takes the value of write-data bit 7 on a 4-byte write to 0x20 and reads back there. Bit 0 cannot be written, and all other status bits read as zero.
- R8: `done_irq` pulses high for exactly one cycle, in the cycle where status bit 0 falls, if and only if status bit 7 is set at that moment.
- R9: A request whose size is not 4 bytes has no effect if it is a write and returns 0xFFFFFFFF if it is a read. This holds at offsets below 0x80 and at every other offset.
- R10: Reads of any offset other than 0x00, 0x04, 0x08 and 0x20 return 0xFFFFFFFF, and writes to such offsets have no effect.
- R11: A synchronous active-low reset clears the operand, the status bits and the scratch register to zero and aborts any computation.
- R12: `rsp_valid` is high in the cycle after each read request and low after every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte address of the access |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| done_irq | output | 1 | One-cycle completion event to the interrupt unit |

## Verification
The bench builds the block with its defaults: a 32-bit data path, an 8-bit byte address and a 4-bit size field. The 8-bit address makes it cheap to read all 256 offsets at sizes 1, 2, 4 and 8 and compare each answer with a model of the map, which covers every unmapped hole and every refused size. The operand is swept from 0 through 34. That range includes the empty product, the last operand whose factorial fits in 32 bits and a stretch of results that wrap. For each operand the bench measures the busy window poll by poll and counts the completion events against the enable bit.

// File: rtl/fa_pkg.sv
// Package fa_pkg
// Shared register selector type, map offsets and status bit positions for the
// factorial accelerator. Assumes a byte-addressed map of 32-bit words.
package fa_pkg;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_ID      = 3'd1,
        SEL_SCRATCH = 3'd2,
        SEL_OPERAND = 3'd3,
        SEL_STATUS  = 3'd4
    } reg_sel_e;

    localparam int OFS_ID      = 'h00;
    localparam int OFS_SCRATCH = 'h04;
    localparam int OFS_OPERAND = 'h08;
    localparam int OFS_STATUS  = 'h20;

    localparam int BUSY_BIT    = 0;
    localparam int IRQEN_BIT   = 7;

    localparam int WORD_BYTES  = 4;
    localparam int SHORT_LIMIT = 'h80;

endpackage

// File: rtl/fa_decode.sv
// Module fa_decode
// Turns a byte address and an access size into one register selector.
// Only full-word accesses at the four mapped offsets select a register.
// Anything else selects SEL_NONE: reads of it answer all ones and writes to
// it are dropped. Purely combinational.
module fa_decode
    import fa_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output reg_sel_e          sel
);

    localparam logic [ADDR_W-1:0] A_ID      = ADDR_W'(OFS_ID);
    localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(OFS_SCRATCH);
    localparam logic [ADDR_W-1:0] A_OPERAND = ADDR_W'(OFS_OPERAND);
    localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
    localparam logic [SIZE_W-1:0] S_WORD    = SIZE_W'(WORD_BYTES);

    logic size_ok;

    // Only full-word accesses may reach a mapped register.
    always_comb begin
        size_ok = (size == S_WORD);
    end

    // Select the register addressed by a well-sized access.
    always_comb begin
        sel = SEL_NONE;
        if (size_ok) begin
            case (addr)
                A_ID:      sel = SEL_ID;
                A_SCRATCH: sel = SEL_SCRATCH;
                A_OPERAND: sel = SEL_OPERAND;
                A_STATUS:  sel = SEL_STATUS;
                default:   sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/fa_engine.sv
// Module fa_engine
// Iterative factorial unit. A start pulse loads the operand as a down-counter
// and sets the accumulator to one. Each busy cycle then multiplies the
// accumulator by the counter and decrements the counter. When the counter
// reaches zero, finish is high for one cycle with the product valid, and busy
// drops at the following edge. The product wraps modulo 2^W. Assumes start is
// only honoured while idle.
module fa_engine #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] operand,
    output logic         busy,
    output logic         finish,
    output logic [W-1:0] product
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] acc_q;
    logic [W-1:0] cnt_q;
    logic         busy_q;

    // Run the load / multiply / retire sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            acc_q  <= '0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            acc_q  <= ONE;
            cnt_q  <= operand;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                acc_q <= acc_q * cnt_q;
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    // Expose state to the register bank.
    always_comb begin
        busy    = busy_q;
        finish  = busy_q && (cnt_q == '0);
        product = acc_q;
    end

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - ONE));

    // R5
    load_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> (busy_q && acc_q == ONE));

    // R6
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == '0) |=> !busy_q);

endmodule

// File: rtl/fa_regbank.sv
// Module fa_regbank
// Holds the scratch, operand and enable registers. Acts on decoded writes,
// answers reads one cycle later, and issues the completion event. Assumes the
// selector comes from fa_decode and that rd_en and wr_en are never both high.
module fa_regbank
    import fa_pkg::*;
#(
    parameter int           W        = 32,
    parameter logic [W-1:0] ID_VALUE = 32'h010000ED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rd_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    input  logic         eng_busy,
    input  logic         eng_finish,
    input  logic [W-1:0] eng_product,
    output logic         eng_start,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_rdata,
    output logic         irq_evt
);

    logic [W-1:0] scratch_q;
    logic [W-1:0] operand_q;
    logic         irq_en_q;
    logic         irq_evt_q;
    logic         rsp_valid_q;
    logic [W-1:0] rsp_rdata_q;
    logic [W-1:0] status_word;
    logic [W-1:0] rd_word;

    // Accept an operand write only while the engine is idle.
    always_comb begin
        eng_start = wr_en && (sel == SEL_OPERAND) && !eng_busy;
    end

    // Scratch register keeps the inverse of the written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
        end else if (wr_en && sel == SEL_SCRATCH) begin
            scratch_q <= ~wdata;
        end
    end

    // Operand register: loaded by software, overwritten by the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            operand_q <= '0;
        end else if (eng_start) begin
            operand_q <= wdata;
        end else if (eng_finish) begin
            operand_q <= eng_product;
        end
    end

    // Completion-event enable bit of the status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= 1'b0;
        end else if (wr_en && sel == SEL_STATUS) begin
            irq_en_q <= wdata[IRQEN_BIT];
        end
    end

    // One-cycle completion event when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_evt_q <= 1'b0;
        end else begin
            irq_evt_q <= eng_finish && irq_en_q;
        end
    end

    // Assemble the status word from live state.
    always_comb begin
        status_word            = '0;
        status_word[BUSY_BIT]  = eng_busy;
        status_word[IRQEN_BIT] = irq_en_q;
    end

    // Read multiplexer; unselected reads answer all ones.
    always_comb begin
        case (sel)
            SEL_ID:      rd_word = ID_VALUE;
            SEL_SCRATCH: rd_word = scratch_q;
            SEL_OPERAND: rd_word = operand_q;
            SEL_STATUS:  rd_word = status_word;
            default:     rd_word = '1;
        endcase
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= rd_en;
            if (rd_en) begin
                rsp_rdata_q <= rd_word;
            end
        end
    end

    // Drive outputs from registered state.
    always_comb begin
        rsp_valid = rsp_valid_q;
        rsp_rdata = rsp_rdata_q;
        irq_evt   = irq_evt_q;
    end

    // R2
    scratch_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_SCRATCH) |=> (scratch_q == ~$past(wdata)));

    // R4
    refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_OPERAND && eng_busy && !eng_finish) |=> $stable(operand_q));

    // R8
    irq_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt_q |=> !irq_evt_q);

    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_evt_q |-> !eng_busy);

    // R12
    rsp_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid_q);

    // R12
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_valid_q);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (operand_q == '0 && scratch_q == '0 && !irq_en_q));

endmodule

// File: rtl/fa_accel.sv
// Module fa_accel
// Top of the register-mapped factorial accelerator. It splits the request
// port into read and write strobes, decodes the address and size, and wires
// the register bank to the iterative engine. Assumes one request per cycle at
// most and no back-pressure on the response.
module fa_accel #(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 8,
    parameter int                SIZE_W   = 4,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h010000ED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              done_irq
);

    import fa_pkg::*;

    reg_sel_e          sel;
    logic              wr_en;
    logic              rd_en;
    logic              eng_start;
    logic              eng_busy;
    logic              eng_finish;
    logic [DATA_W-1:0] eng_product;

    // Split the request into write and read strobes.
    always_comb begin
        wr_en = req_valid && req_write;
        rd_en = req_valid && !req_write;
    end

    fa_decode #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_decode (
        .addr (req_addr),
        .size (req_size),
        .sel  (sel)
    );

    fa_regbank #(
        .W        (DATA_W),
        .ID_VALUE (ID_VALUE)
    ) u_regbank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .sel         (sel),
        .wdata       (req_wdata),
        .eng_busy    (eng_busy),
        .eng_finish  (eng_finish),
        .eng_product (eng_product),
        .eng_start   (eng_start),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .irq_evt     (done_irq)
    );

    fa_engine #(
        .W (DATA_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .operand (req_wdata),
        .busy    (eng_busy),
        .finish  (eng_finish),
        .product (eng_product)
    );

    // R8
    irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $fell(eng_busy));

endmodule

// File: tb/fa_accel_tb.sv
module fa_accel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        done_irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit irq_prev = 1'b0;
    bit finished = 1'b0;

    localparam logic [31:0] ID_WORD = 32'h010000ED;
    localparam logic [31:0] ONES    = 32'hFFFFFFFF;

    always #10 clk = ~clk;

    fa_accel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .done_irq  (done_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R8: count completion events and catch any that last two cycles
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_irq) irq_cnt++;
            if (done_irq && irq_prev) begin
                checks++;
                errors++;
                $display("FAIL R8 actual=two-cycle event expected=one-cycle event");
            end
        end
        irq_prev = done_irq;
    end

    // Called at a negedge; returns at the next negedge.
    task automatic wr(input logic [7:0] a, input logic [3:0] s, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(rsp_valid == 1'b0, "R12 no response after write", 32'(rsp_valid), 32'd0);
    endtask

    task automatic rd(input logic [7:0] a, input logic [3:0] s, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R12 response after read", 32'(rsp_valid), 32'd1);
        d = rsp_rdata;
    endtask

    function automatic logic [31:0] fact(input int n);
        logic [31:0] p = 32'd1;
        for (int i = n; i > 0; i--) p = p * 32'(i);
        return p;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=run to completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] scr_m;
        logic [31:0] op_m;
        logic [31:0] st_m;
        logic [31:0] exp;
        int busy_polls;
        int irq_before;
        bit en;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        rd(8'h08, 4'd4, v); chk(v == 32'd0, "R11 operand after reset", v, 32'd0);
        rd(8'h20, 4'd4, v); chk(v == 32'd0, "R11 status after reset", v, 32'd0);
        rd(8'h04, 4'd4, v); chk(v == 32'd0, "R11 scratch after reset", v, 32'd0);

        // R1: identification word, write ignored
        rd(8'h00, 4'd4, v); chk(v == ID_WORD, "R1 id", v, ID_WORD);
        wr(8'h00, 4'd4, 32'h12345678);
        rd(8'h00, 4'd4, v); chk(v == ID_WORD, "R1 id after write", v, ID_WORD);

        // R2: scratch complement
        foreach (scr_m[i]) begin end
        for (int k = 0; k < 6; k++) begin
            logic [31:0] d;
            d = 32'hA5A5_0000 ^ (32'h1 << (k * 5)) ^ 32'(k * 32'h01010101);
            wr(8'h04, 4'd4, d);
            rd(8'h04, 4'd4, v); chk(v == ~d, "R2 scratch inverse", v, ~d);
        end
        wr(8'h04, 4'd4, 32'h0F0F_3C3C);
        scr_m = 32'hF0F0_C3C3;

        // R9: short and long writes dropped
        wr(8'h04, 4'd2, 32'h0);
        wr(8'h04, 4'd8, 32'h0);
        wr(8'h08, 4'd1, 32'd5);
        rd(8'h04, 4'd4, v); chk(v == scr_m, "R9 scratch unchanged by bad size", v, scr_m);
        rd(8'h20, 4'd4, v); chk(v == 32'd0, "R9 no start on bad size", v, 32'd0);
        wr(8'h20, 4'd2, 32'h80);
        rd(8'h20, 4'd4, v); chk(v == 32'd0, "R9 status unchanged by bad size", v, 32'd0);

        // R10: unmapped writes have no effect
        wr(8'h0C, 4'd4, 32'h0);
        wr(8'h24, 4'd4, 32'h80);
        wr(8'h80, 4'd4, 32'd3);
        rd(8'h04, 4'd4, v); chk(v == scr_m, "R10 scratch unchanged", v, scr_m);
        rd(8'h20, 4'd4, v); chk(v == 32'd0, "R10 status unchanged", v, 32'd0);
        rd(8'h08, 4'd4, v); chk(v == 32'd0, "R10 operand unchanged", v, 32'd0);

        // R7: only bit 7 of status is writable
        wr(8'h20, 4'd4, ONES);
        rd(8'h20, 4'd4, v); chk(v == 32'h80, "R7 status set", v, 32'h80);
        wr(8'h20, 4'd4, 32'hFFFF_FF7F);
        rd(8'h20, 4'd4, v); chk(v == 32'h0, "R7 status clear", v, 32'h0);
        st_m = 32'h0;

        // R9 R10: sweep every offset and size against the map model
        op_m = 32'd0;
        for (int a = 0; a < 256; a++) begin
            for (int si = 0; si < 4; si++) begin
                logic [3:0] s;
                s = 4'(1 << si);
                exp = ONES;
                if (s == 4'd4) begin
                    case (a)
                        'h00: exp = ID_WORD;
                        'h04: exp = scr_m;
                        'h08: exp = op_m;
                        'h20: exp = st_m;
                        default: exp = ONES;
                    endcase
                end
                rd(8'(a), s, v);
                chk(v == exp, (s == 4'd4) ? "R10 map sweep" : "R9 size sweep", v, exp);
            end
        end

        // R3 R5 R6 R7 R8: operand sweep
        for (int n = 0; n <= 34; n++) begin
            en = (n % 3) != 0;
            wr(8'h20, 4'd4, en ? 32'h80 : 32'h0);
            irq_before = irq_cnt;
            wr(8'h08, 4'd4, 32'(n));
            rd(8'h08, 4'd4, v); chk(v == 32'(n), "R3 operand visible while busy", v, 32'(n));
            busy_polls = 0;
            for (int p = 0; p < 100; p++) begin
                rd(8'h20, 4'd4, v);
                if (v[0]) busy_polls++;
                else break;
            end
            chk(busy_polls == n, "R6 busy window", 32'(busy_polls), 32'(n));
            chk(v == (en ? 32'h80 : 32'h0), "R7 status after completion", v,
                en ? 32'h80 : 32'h0);
            rd(8'h08, 4'd4, v); chk(v == fact(n), "R5 factorial result", v, fact(n));
            chk(irq_cnt - irq_before == (en ? 1 : 0), "R8 completion events",
                32'(irq_cnt - irq_before), en ? 32'd1 : 32'd0);
        end

        // R4: write while busy is refused
        wr(8'h20, 4'd4, 32'h0);
        wr(8'h08, 4'd4, 32'd5);
        wr(8'h08, 4'd4, 32'd9);
        rd(8'h08, 4'd4, v); chk(v == 32'd5, "R4 operand kept while busy", v, 32'd5);
        repeat (12) @(negedge clk);
        rd(8'h08, 4'd4, v); chk(v == 32'd120, "R4 result of first operand", v, 32'd120);
        rd(8'h20, 4'd4, v); chk(v == 32'd0, "R4 engine idle after refusal", v, 32'd0);

        // R11: reset during a computation
        wr(8'h20, 4'd4, 32'h80);
        wr(8'h04, 4'd4, 32'h0);
        wr(8'h08, 4'd4, 32'd20);
        irq_before = irq_cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'h08, 4'd4, v); chk(v == 32'd0, "R11 operand cleared", v, 32'd0);
        rd(8'h20, 4'd4, v); chk(v == 32'd0, "R11 status cleared", v, 32'd0);
        rd(8'h04, 4'd4, v); chk(v == 32'd0, "R11 scratch cleared", v, 32'd0);
        repeat (30) @(negedge clk);
        chk(irq_cnt == irq_before, "R11 no event after abort", 32'(irq_cnt),
            32'(irq_before));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule